// File: doc/BRIEF.md
# Serial Flash Command Guard

This block is the slave-side command front end of a small serial flash with a four-wire interface. While the active-low select is held low, the block shifts in one bit from the serial input on each rising serial-clock edge, most significant bit first. The first byte is taken as the command code and any later bytes as operands. Commands that change state take effect only when the select returns high on a whole-byte boundary. Every command that modifies state is gated on a write-enable latch kept in a status byte. The latch clears itself once the operation completes, so each change to the array or to the protect setting needs a fresh enable.

The storage is a small byte-wide register file split into equal sectors. Programming and erasing behave as in flash: cells start at all ones, a program can only clear bits, and an erase returns a whole sector, or the whole array, to all ones. A protect level held in the status byte guards the upper sectors. Each accepted modifying command holds a busy flag for a fixed number of core clock cycles, and its effect lands when the busy window ends. The serial output goes to a pad cell as a data bit plus an output enable. The pad is high-impedance whenever the enable is low, and the enable is raised only while the status byte or array data is being returned.

Serial clock, select and data input are sampled by the core clock and are assumed synchronous to it, with every serial level lasting at least two core cycles.

Top module: `sflash_cmd_guard`

## Requirements
- R1: After reset the status byte reads 8'h00, every array byte reads 8'hFF and the output enable is low.
- R2: Command bytes are shifted in MSB first on serial-clock rising edges while select is low; a command whose select rises after a bit count that is not a multiple of 8 has no effect.
- R3: Command 8'h06 sets the write-enable latch (status bit 1) and command 8'h04 clears it.
- R4: After command 8'h05 the block drives the status byte MSB first, one bit per serial clock and repeating for as long as select stays low. Status layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 protect level, bits 7:4 zero. The output enable is low whenever select is high and during command and operand bytes.
- R5: A write-status, program, sector-erase or bulk-erase command issued while the write-enable latch is 0 has no effect.
- R6: Command 8'h01 followed by one byte loads the protect level from bits 3:2 of that byte when the operation completes, WRSR_CYC cycles after acceptance; the other bits of that byte are ignored.
- R7: An accepted modifying command sets busy (status bit 0) for its cycle count. While busy, only command 8'h05 is honoured: commands that modify state and array reads are ignored.
- R8: The write-enable latch clears when a write-status, program, sector-erase or bulk-erase operation completes.
- R9: Command 8'h02 followed by an address byte and a data byte ANDs the data into the addressed byte, so bits only go from 1 to 0; bytes after the first data byte are ignored.
- R10: Command 8'hD8 followed by an address byte sets all bytes of the sector that holds the address to 8'hFF; the sector is address bits [3:2] under the default parameters.
- R11: Command 8'hC7 sets the whole array to 8'hFF, and it has no effect unless the protect level is 0.
- R12: Protect level L guards sectors whose index is at least 4-L; a program or sector erase aimed at a guarded sector has no effect, starts no busy window and leaves the latch set.
- R13: Command 8'h03 followed by an address byte returns array bytes MSB first from that address, incrementing and wrapping from the top address to 0.
- R14: Any command code not listed above has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data into the block |
| so_data | output | 1 | Serial data bit toward the output pad |
| so_en | output | 1 | Output enable for the pad; pad is high-impedance when low |

## Verification
The bench uses the default parameters: a 16-byte array in four sectors of four bytes, and busy windows of 300, 400, 500 and 600 core cycles for status write, program, sector erase and bulk erase. These windows are long enough for a status poll, a second program command and an array read to fit inside one program window, so the busy gating can be seen at the pins. With four sectors, protect level 3 guards every sector except sector 0. Guarded and unguarded targets are therefore both reachable, and the bulk-erase refusal can be shown against a nonzero level before the level is cleared again.

// File: rtl/sflash_cmd_pkg.sv
package sflash_cmd_pkg;
  localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
  localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
  localparam logic [7:0] CMD_STAT_RD   = 8'h05;
  localparam logic [7:0] CMD_STAT_WR   = 8'h01;
  localparam logic [7:0] CMD_PROGRAM   = 8'h02;
  localparam logic [7:0] CMD_SECT_ERS  = 8'hD8;
  localparam logic [7:0] CMD_BULK_ERS  = 8'hC7;
  localparam logic [7:0] CMD_ARRAY_RD  = 8'h03;

  localparam int STAT_BUSY = 0;
  localparam int STAT_WEL  = 1;
  localparam int STAT_PROT = 2;

  typedef enum logic [2:0] {
    JOB_IDLE, JOB_STAT, JOB_PROG, JOB_SECT, JOB_BULK
  } job_e;
endpackage

// File: rtl/sflash_rx.sv
module sflash_rx #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             sdi,
  output logic             bit_rise,
  output logic             byte_stb,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             on_boundary,
  output logic             cs_rise
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             sck_q, cs_q;
  logic [2:0]       bit_q, bit_d;
  logic [6:0]       sh_q, sh_d;
  logic [CNT_W-1:0] cnt_d;

  assign bit_rise    = sck & ~sck_q & ~cs_n;
  assign byte_stb    = bit_rise & (bit_q == 3'd7);
  assign byte_val    = {sh_q, sdi};
  assign on_boundary = (bit_q == 3'd0);
  assign cs_rise     = cs_n & ~cs_q;

  always_comb begin
    bit_d = bit_q;
    sh_d  = sh_q;
    cnt_d = byte_cnt;
    if (cs_n) begin
      bit_d = 3'd0;
      cnt_d = '0;
    end else if (bit_rise) begin
      bit_d = bit_q + 3'd1;
      sh_d  = {sh_q[5:0], sdi};
      if ((bit_q == 3'd7) && (byte_cnt != CNT_TOP)) cnt_d = byte_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      bit_q    <= 3'd0;
      sh_q     <= 7'd0;
      byte_cnt <= '0;
    end else begin
      sck_q    <= sck;
      cs_q     <= cs_n;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      byte_cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/sflash_array.sv
module sflash_array #(
  parameter int ADDR_W = 4,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              sect_en,
  input  logic [SECT_W-1:0] sect_idx,
  input  logic              bulk_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][7:0] words;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
    logic       hit_ers, hit_prog;
    logic [7:0] word_q, word_d;

    assign hit_ers  = bulk_en | (sect_en & (sect_idx == WA[ADDR_W-1 -: SECT_W]));
    assign hit_prog = prog_en & (prog_addr == WA);

    always_comb begin
      word_d = word_q;
      if (hit_ers)       word_d = 8'hFF;
      else if (hit_prog) word_d = word_q & prog_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 word_q <= 8'hFF;
      else if (hit_ers | hit_prog) word_q <= word_d;
    end

    assign words[w] = word_q;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
  import sflash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int SECT_W   = 2,
  parameter int CNT_W    = 3,
  parameter int WRSR_CYC = 300,
  parameter int PROG_CYC = 400,
  parameter int SECT_CYC = 500,
  parameter int BULK_CYC = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_rise,
  input  logic              byte_stb,
  input  logic [7:0]        byte_val,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              on_boundary,
  input  logic              cs_rise,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              prog_en,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              sect_en,
  output logic [SECT_W-1:0] sect_idx,
  output logic              bulk_en,
  output logic              so_data,
  output logic              so_en,
  output logic [7:0]        status
);
  localparam int MAX_A  = (WRSR_CYC > PROG_CYC) ? WRSR_CYC : PROG_CYC;
  localparam int MAX_B  = (SECT_CYC > BULK_CYC) ? SECT_CYC : BULK_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_C + 1);
  localparam int NSECT  = 1 << SECT_W;
  localparam logic [SECT_W:0] SECT_LIM = (SECT_W+1)'(NSECT);

  logic [7:0]        op_q, op_d, arg_q, arg_d, dat_q, dat_d;
  logic              wel_q, wel_d;
  logic [SECT_W-1:0] prot_q, prot_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  job_e              job_q, job_d;
  logic [ADDR_W-1:0] jaddr_q, jaddr_d, rptr_q, rptr_d;
  logic [7:0]        jdat_q, jdat_d, osh_q, osh_d;
  logic [2:0]        oidx_q, oidx_d;
  logic              oen_q, oen_d;
  logic              busy, finish, cmd_go, tgt_guarded, addr_phase;
  logic [SECT_W-1:0] tgt_sect;

  assign busy        = (tmr_q != '0);
  assign finish      = (tmr_q == TMR_W'(1));
  assign cmd_go      = cs_rise & on_boundary & ~busy & (byte_cnt != '0);
  assign tgt_sect    = arg_q[ADDR_W-1 -: SECT_W];
  assign tgt_guarded = (({1'b0, tgt_sect} + {1'b0, prot_q}) >= SECT_LIM);
  assign addr_phase  = byte_stb & (byte_cnt == CNT_W'(1));
  assign rd_addr     = addr_phase ? byte_val[ADDR_W-1:0] : rptr_q;

  always_comb begin
    status = 8'h00;
    status[STAT_BUSY] = busy;
    status[STAT_WEL]  = wel_q;
    status[STAT_PROT +: SECT_W] = prot_q;
  end

  always_comb begin
    op_d = op_q;   arg_d = arg_q;   dat_d = dat_q;
    wel_d = wel_q; prot_d = prot_q; tmr_d = tmr_q; job_d = job_q;
    jaddr_d = jaddr_q; jdat_d = jdat_q; rptr_d = rptr_q;
    osh_d = osh_q; oidx_d = oidx_q; oen_d = oen_q;
    prog_en = 1'b0; sect_en = 1'b0; bulk_en = 1'b0;

    // busy window and deferred effect
    if (busy) begin
      tmr_d = tmr_q - 1'b1;
      if (finish) begin
        case (job_q)
          JOB_STAT: prot_d  = jdat_q[STAT_PROT +: SECT_W];
          JOB_PROG: prog_en = 1'b1;
          JOB_SECT: sect_en = 1'b1;
          JOB_BULK: bulk_en = 1'b1;
          default:  ;
        endcase
        wel_d = 1'b0;
        job_d = JOB_IDLE;
      end
    end

    // output serializer
    if (oen_q && bit_rise) begin
      oidx_d = oidx_q - 3'd1;
      if ((oidx_q == 3'd0) && (op_q == CMD_ARRAY_RD)) begin
        osh_d  = rd_data;
        rptr_d = rptr_q + 1'b1;
      end
    end

    // byte capture
    if (byte_stb) begin
      if (byte_cnt == '0) begin
        op_d = byte_val;
        if (byte_val == CMD_STAT_RD) begin
          oen_d  = 1'b1;
          oidx_d = 3'd7;
        end
      end else if (byte_cnt == CNT_W'(1)) begin
        arg_d = byte_val;
        if ((op_q == CMD_ARRAY_RD) && !busy) begin
          osh_d  = rd_data;
          rptr_d = byte_val[ADDR_W-1:0] + 1'b1;
          oen_d  = 1'b1;
          oidx_d = 3'd7;
        end
      end else if (byte_cnt == CNT_W'(2)) begin
        dat_d = byte_val;
      end
    end

    if (cs_n) oen_d = 1'b0;

    // commit at select release
    if (cmd_go) begin
      case (op_q)
        CMD_LATCH_ON:  wel_d = 1'b1;
        CMD_LATCH_OFF: wel_d = 1'b0;
        CMD_STAT_WR: if (wel_q && (byte_cnt >= CNT_W'(2))) begin
          job_d = JOB_STAT; jdat_d = arg_q; tmr_d = TMR_W'(WRSR_CYC);
        end
        CMD_PROGRAM: if (wel_q && (byte_cnt >= CNT_W'(3)) && !tgt_guarded) begin
          job_d = JOB_PROG; jaddr_d = arg_q[ADDR_W-1:0]; jdat_d = dat_q;
          tmr_d = TMR_W'(PROG_CYC);
        end
        CMD_SECT_ERS: if (wel_q && (byte_cnt >= CNT_W'(2)) && !tgt_guarded) begin
          job_d = JOB_SECT; jaddr_d = arg_q[ADDR_W-1:0]; tmr_d = TMR_W'(SECT_CYC);
        end
        CMD_BULK_ERS: if (wel_q && (prot_q == '0)) begin
          job_d = JOB_BULK; tmr_d = TMR_W'(BULK_CYC);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= 8'h00; arg_q <= 8'h00; dat_q <= 8'h00;
      wel_q <= 1'b0; prot_q <= '0; tmr_q <= '0; job_q <= JOB_IDLE;
      jaddr_q <= '0; jdat_q <= 8'h00; rptr_q <= '0;
      osh_q <= 8'h00; oidx_q <= 3'd7; oen_q <= 1'b0;
    end else begin
      op_q <= op_d; arg_q <= arg_d; dat_q <= dat_d;
      wel_q <= wel_d; prot_q <= prot_d; tmr_q <= tmr_d; job_q <= job_d;
      jaddr_q <= jaddr_d; jdat_q <= jdat_d; rptr_q <= rptr_d;
      osh_q <= osh_d; oidx_q <= oidx_d; oen_q <= oen_d;
    end
  end

  assign prog_addr = jaddr_q;
  assign prog_data = jdat_q;
  assign sect_idx  = jaddr_q[ADDR_W-1 -: SECT_W];
  assign so_en     = oen_q;
  assign so_data   = (op_q == CMD_STAT_RD) ? status[oidx_q] : osh_q[oidx_q];
endmodule

// File: rtl/sflash_cmd_guard.sv
module sflash_cmd_guard #(
  parameter int ADDR_W   = 4,
  parameter int SECT_W   = 2,
  parameter int WRSR_CYC = 300,
  parameter int PROG_CYC = 400,
  parameter int SECT_CYC = 500,
  parameter int BULK_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic so_data,
  output logic so_en
);
  localparam int CNT_W = 3;

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              bit_rise, byte_stb, on_boundary, cs_rise;
  logic [7:0]        byte_val, rd_data, prog_data, status_w;
  logic [CNT_W-1:0]  byte_cnt;
  logic [ADDR_W-1:0] rd_addr, prog_addr;
  logic [SECT_W-1:0] sect_idx;
  logic              prog_en, sect_en, bulk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  sflash_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .bit_rise(bit_rise), .byte_stb(byte_stb), .byte_val(byte_val),
    .byte_cnt(byte_cnt), .on_boundary(on_boundary), .cs_rise(cs_rise)
  );

  sflash_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .CNT_W(CNT_W),
    .WRSR_CYC(WRSR_CYC), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .BULK_CYC(BULK_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .cs_n(cs_n),
    .bit_rise(bit_rise), .byte_stb(byte_stb), .byte_val(byte_val),
    .byte_cnt(byte_cnt), .on_boundary(on_boundary), .cs_rise(cs_rise),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
    .sect_en(sect_en), .sect_idx(sect_idx), .bulk_en(bulk_en),
    .so_data(so_data), .so_en(so_en), .status(status_w)
  );

  sflash_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_core_n),
    .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
    .sect_en(sect_en), .sect_idx(sect_idx), .bulk_en(bulk_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/sflash_cmd_guard_chk.sv
module sflash_cmd_guard_chk #(
  parameter int SECT_W = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_en,
  input logic [7:0] status
);
  logic              busy, wel;
  logic [SECT_W-1:0] prot;

  assign busy = status[0];
  assign wel  = status[1];
  assign prot = status[2 +: SECT_W];

  AST_SO_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !so_en); // R4

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R5

  AST_PROT_CHANGES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (prot != $past(prot)) |-> $fell(busy)); // R6

  AST_WEL_RISES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy)); // R7

  AST_WEL_CLEARED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R8
endmodule

bind sflash_cmd_guard sflash_cmd_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_en(so_en), .status(status_w)
);

// File: tb/tb_sflash_cmd_guard.sv
module tb_sflash_cmd_guard;
  logic clk, rst_n, sck, cs_n, sdi;
  logic so_data, so_en;
  int   n_chk, n_fail;
  logic saw_en, done;

  sflash_cmd_guard dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .so_data(so_data), .so_en(so_en)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] a;
    logic [7:0] d;
    logic [1:0] nb;
    logic [3:0] chk_addr;
    logic [7:0] exp_st;
    logic [7:0] exp_mem;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 8'h05, 8'h00, 2'd3, 4'h5, 8'h00, 8'hFF, 4'd5 },  // R5 program without latch
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h5, 8'h02, 8'hFF, 4'd3 },  // R3 latch on
    '{8'h04, 8'h00, 8'h00, 2'd1, 4'h5, 8'h00, 8'hFF, 4'd3 },  // R3 latch off
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h5, 8'h02, 8'hFF, 4'd3 },
    '{8'h02, 8'h05, 8'h5A, 2'd3, 4'h5, 8'h00, 8'h5A, 4'd9 },  // R9 program, R8 latch cleared
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h5, 8'h02, 8'h5A, 4'd3 },
    '{8'h02, 8'h05, 8'hF0, 2'd3, 4'h5, 8'h00, 8'h50, 4'd9 },  // R9 AND only
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h5, 8'h02, 8'h50, 4'd3 },
    '{8'hD8, 8'h04, 8'h00, 2'd2, 4'h5, 8'h00, 8'hFF, 4'd10},  // R10 sector 1 erase
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h5, 8'h02, 8'hFF, 4'd3 },
    '{8'h01, 8'hFF, 8'h00, 2'd2, 4'h5, 8'h0C, 8'hFF, 4'd6 },  // R6 level 3 only
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h5, 8'h0E, 8'hFF, 4'd3 },
    '{8'h02, 8'h0A, 8'h00, 2'd3, 4'hA, 8'h0E, 8'hFF, 4'd12},  // R12 guarded sector 2
    '{8'h02, 8'h01, 8'h3C, 2'd3, 4'h1, 8'h0C, 8'h3C, 4'd12},  // R12 sector 0 open
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h1, 8'h0E, 8'h3C, 4'd3 },
    '{8'hC7, 8'h00, 8'h00, 2'd1, 4'h1, 8'h0E, 8'h3C, 4'd11},  // R11 bulk refused
    '{8'h9F, 8'h00, 8'h00, 2'd1, 4'h1, 8'h0E, 8'h3C, 4'd14},  // R14 unknown code
    '{8'h01, 8'h00, 8'h00, 2'd2, 4'h1, 8'h00, 8'h3C, 4'd6 },  // R6 level back to 0
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'h1, 8'h02, 8'h3C, 4'd3 },
    '{8'hC7, 8'h00, 8'h00, 2'd1, 4'h1, 8'h00, 8'hFF, 4'd11},  // R11 bulk erase
    '{8'h06, 8'h00, 8'h00, 2'd1, 4'hF, 8'h02, 8'hFF, 4'd3 },
    '{8'h02, 8'h0F, 8'h81, 2'd3, 4'hF, 8'h00, 8'h81, 4'd9 }   // R9 top address
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      repeat (2) @(negedge clk);
      rx[i] = so_data;
      if (so_en) saw_en = 1'b1;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [7:0] a,
                          input logic [7:0] d, input logic [1:0] nb);
    logic [7:0] junk;
    sel_on();
    xfer_byte(op, junk);
    if (nb > 2'd1) xfer_byte(a, junk);
    if (nb > 2'd2) xfer_byte(d, junk);
    sel_off();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] junk;
    sel_on();
    xfer_byte(8'h05, junk);
    xfer_byte(8'h00, s);
    sel_off();
  endtask

  task automatic read_mem(input logic [7:0] addr, output logic [7:0] v);
    logic [7:0] junk;
    sel_on();
    xfer_byte(8'h03, junk);
    xfer_byte(addr, junk);
    xfer_byte(8'h00, v);
    sel_off();
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2, junk;
    n_chk = 0; n_fail = 0; saw_en = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1", {7'd0, so_en}, 8'h00);
    read_status(v);  check("R1", v, 8'h00);
    read_mem(8'h00, v); check("R1", v, 8'hFF);
    read_mem(8'h0E, v); check("R1", v, 8'hFF);

    // table walk
    for (int k = 0; k < NV; k++) begin
      send_cmd(VECS[k].op, VECS[k].a, VECS[k].d, VECS[k].nb);
      repeat (700) @(negedge clk);
      read_status(v);
      check($sformatf("R%0d status", VECS[k].req), v, VECS[k].exp_st);
      read_mem({4'h0, VECS[k].chk_addr}, v);
      check($sformatf("R%0d array", VECS[k].req), v, VECS[k].exp_mem);
    end

    // R13 read with increment and wrap
    sel_on();
    xfer_byte(8'h03, junk);
    xfer_byte(8'h0F, junk);
    xfer_byte(8'h00, v);
    xfer_byte(8'h00, v2);
    sel_off();
    check("R13 first", v, 8'h81);
    check("R13 wrap", v2, 8'hFF);

    // R4 repeating status, quiet output during command bytes
    send_cmd(8'h06, 8'h00, 8'h00, 2'd1);
    sel_on();
    saw_en = 1'b0;
    xfer_byte(8'h05, junk);
    check("R4 quiet opcode", {7'd0, saw_en}, 8'h00);
    xfer_byte(8'h00, v);
    xfer_byte(8'h00, v2);
    sel_off();
    check("R4 status", v, 8'h02);
    check("R4 repeat", v2, 8'h02);
    check("R4 deselected", {7'd0, so_en}, 8'h00);
    send_cmd(8'h04, 8'h00, 8'h00, 2'd1);

    // R2 select released off a byte boundary
    sel_on();
    xfer_byte(8'h06, junk);
    sdi = 1'b0; repeat (2) @(negedge clk); sck = 1'b1; repeat (2) @(negedge clk); sck = 1'b0;
    sel_off();
    read_status(v); check("R2 nine bits", v, 8'h00);
    sel_on();
    for (int i = 7; i >= 1; i--) begin
      sdi = 1'(8'h06 >> i); repeat (2) @(negedge clk);
      sck = 1'b1; repeat (2) @(negedge clk); sck = 1'b0;
    end
    sel_off();
    read_status(v); check("R2 seven bits", v, 8'h00);

    // R7 busy window behaviour
    send_cmd(8'h06, 8'h00, 8'h00, 2'd1);
    send_cmd(8'h02, 8'h02, 8'h11, 2'd3);
    read_status(v); check("R7 busy", v, 8'h03);
    send_cmd(8'h02, 8'h03, 8'h00, 2'd3);
    saw_en = 1'b0;
    read_mem(8'h00, v);
    check("R7 read ignored", {7'd0, saw_en}, 8'h00);
    repeat (700) @(negedge clk);
    read_status(v);     check("R8 after program", v, 8'h00);
    read_mem(8'h02, v); check("R9 programmed", v, 8'h11);
    read_mem(8'h03, v); check("R7 second program dropped", v, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule